// File: doc/BRIEF.md
# Grid Dimming Pulse-Width Modulator

This block produces the drive-enable pulse for one grid period of a multiplexed vacuum-fluorescent display. A grid period is split into sixteen equal sub-slices. An external sequencer marks each sub-slice with a one-cycle tick, and each new grid period with a one-cycle start strobe. The block holds its drive output high for a number of leading sub-slices chosen by a 3-bit brightness level. It holds the output low for the rest of the period.

The eight levels follow a fixed, non-linear width table. The lowest widths are small and closely spaced, for dim settings. The upper five widths sit near full brightness. At least two sub-slices at the end of every period stay dark, which gives blanking between digits. The level is captured only at the start strobe, so a level change never cuts short or extends a period that is already running. The drive output comes straight from a flop.

Top module: `dim_grid_pwm`

## Requirements
- R1: While reset is asserted, and after it is released, the drive output is low and no period is running.
- R2: A start strobe captures the level input and begins a period at sub-slice 0. The drive output goes high in the clock cycle after the strobe edge.
- R3: Levels 3'b000 to 3'b111 select widths of 1, 2, 4, 10, 11, 12, 13 and 14 sub-slices, in that order.
- R4: For a width of N, the drive output is high during sub-slices 0 to N-1 and low during sub-slices N to 15.
- R5: The sub-slice index advances only on a tick. Without ticks, the drive output holds its value for any number of cycles.
- R6: A level change between two start strobes has no effect on the period that is running.
- R7: A start strobe during a running period restarts it at sub-slice 0 with the newly captured level.
- R8: The tick in sub-slice 15 ends the period. The drive output then stays low, whatever ticks follow, until the next start strobe.
- R9: A start strobe seen while reset is asserted is ignored. No period runs after reset is released until a new strobe arrives.
- R10: The last two sub-slices of every period are always dark, at every level.
- R11: When a start strobe and a tick arrive in the same cycle, the strobe wins and the period begins at sub-slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slice_tick_i | input | 1 | One-cycle pulse that ends the current sub-slice |
| grid_start_i | input | 1 | One-cycle pulse that begins a grid period |
| level_i | input | 3 | Brightness level, captured at the start strobe |
| drive_en_o | output | 1 | Drive enable for the active grid |

## Verification
All eight levels are run through complete periods, and the output is compared against the expected width at every sub-slice. This separates table entries that differ by a single sub-slice, and it exposes an off-by-one at the falling edge. Other patterns change the level in mid-period, restart a period in mid-period, send a strobe and a tick in the same cycle, hold off ticks for long stretches, and send ticks after a period has ended. These cases separate sampling at the strobe from continuous sampling, show the strobe's priority over the tick, and show that the period ends for good. Strobes sent during reset, and a reset in the middle of a period, show that the reset clears the block completely.

// File: rtl/dim_grid_pkg.sv
package dim_grid_pkg;

   localparam int unsigned LEVEL_W    = 3;
   localparam int unsigned BASE_SLICE = 16;

   // Width, in sixteenths, for each level: non-linear brightness ramp.
   function automatic int unsigned level_sixteenths(input logic [LEVEL_W-1:0] lvl);
      unique case (lvl)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 4;
         3'd3:    return 10;
         3'd4:    return 11;
         3'd5:    return 12;
         3'd6:    return 13;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/dim_width_lut.sv
module dim_width_lut
   import dim_grid_pkg::*;
#(
   parameter int unsigned SLICES = 16,
   localparam int unsigned WID_W = $clog2(SLICES + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [LEVEL_W-1:0] level_i,
   output logic [WID_W-1:0]   width_d_o,
   output logic [WID_W-1:0]   width_q_o
);

   logic [WID_W-1:0] decoded;

   generate
      if (SLICES == BASE_SLICE) begin : g_direct
         always_comb decoded = WID_W'(level_sixteenths(level_i));
      end else begin : g_scaled
         always_comb decoded = WID_W'((level_sixteenths(level_i) * SLICES) / BASE_SLICE);
      end
   endgenerate

   assign width_d_o = start_i ? decoded : width_q_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) width_q_o <= '0;
      else         width_q_o <= width_d_o;
   end

   AST_WIDTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(width_q_o)) else $error("width changed without start"); // R6

   AST_WIDTH_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (width_q_o != '0)) else $error("zero width captured"); // R3

endmodule

// File: rtl/dim_slice_ctr.sv
module dim_slice_ctr #(
   parameter int unsigned SLICES = 16,
   localparam int unsigned SLICE_W = $clog2(SLICES)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic               tick_i,
   output logic [SLICE_W-1:0] slice_d_o,
   output logic               active_d_o,
   output logic [SLICE_W-1:0] slice_q_o,
   output logic               active_q_o
);

   localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES - 1);

   always_comb begin
      slice_d_o  = slice_q_o;
      active_d_o = active_q_o;
      if (start_i) begin
         slice_d_o  = '0;
         active_d_o = 1'b1;
      end else if (tick_i && active_q_o) begin
         if (slice_q_o == LAST) begin
            slice_d_o  = '0;
            active_d_o = 1'b0;
         end else begin
            slice_d_o = slice_q_o + SLICE_W'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slice_q_o  <= '0;
         active_q_o <= 1'b0;
      end else begin
         slice_q_o  <= slice_d_o;
         active_q_o <= active_d_o;
      end
   end

   AST_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (active_q_o && slice_q_o == '0)) else $error("start did not clear"); // R11

   AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !tick_i) |=> ($stable(slice_q_o) && $stable(active_q_o))) else $error("moved without tick"); // R5

   AST_PERIOD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && tick_i && active_q_o && slice_q_o == LAST) |=> !active_q_o) else $error("period overran"); // R8

   AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !active_q_o) |=> !active_q_o) else $error("woke without start"); // R9

endmodule

// File: rtl/dim_drive_stage.sv
module dim_drive_stage #(
   parameter int unsigned SLICES = 16,
   localparam int unsigned SLICE_W = $clog2(SLICES),
   localparam int unsigned WID_W   = $clog2(SLICES + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               active_d_i,
   input  logic [SLICE_W-1:0] slice_d_i,
   input  logic [WID_W-1:0]   width_d_i,
   output logic               drive_o
);

   logic drive_d;

   always_comb drive_d = active_d_i && (WID_W'(slice_d_i) < width_d_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drive_o <= 1'b0;
      else         drive_o <= drive_d;
   end

   AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_d_i |=> !drive_o) else $error("drive outside period"); // R8

endmodule

// File: rtl/dim_grid_pwm.sv
module dim_grid_pwm
   import dim_grid_pkg::*;
#(
   parameter int unsigned SLICES    = 16,
   parameter int unsigned BLANK_MIN = 2,
   localparam int unsigned SLICE_W  = $clog2(SLICES),
   localparam int unsigned WID_W    = $clog2(SLICES + 1),
   localparam int unsigned MAX_WID  = (14 * SLICES) / BASE_SLICE
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               slice_tick_i,
   input  logic               grid_start_i,
   input  logic [LEVEL_W-1:0] level_i,
   output logic               drive_en_o
);

   generate
      if (SLICES < BASE_SLICE || (SLICES % BASE_SLICE) != 0) begin : g_bad_slices
         $error("SLICES must be a positive multiple of 16");
      end
      if (MAX_WID + BLANK_MIN > SLICES) begin : g_bad_blank
         $error("widest level leaves fewer than BLANK_MIN dark slices");
      end
   endgenerate

   logic [SLICE_W-1:0] slice_d, slice_q;
   logic               active_d, active_q;
   logic [WID_W-1:0]   width_d, width_q;

   dim_slice_ctr #(.SLICES(SLICES)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (grid_start_i),
      .tick_i     (slice_tick_i),
      .slice_d_o  (slice_d),
      .active_d_o (active_d),
      .slice_q_o  (slice_q),
      .active_q_o (active_q)
   );

   dim_width_lut #(.SLICES(SLICES)) u_lut (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (grid_start_i),
      .level_i   (level_i),
      .width_d_o (width_d),
      .width_q_o (width_q)
   );

   dim_drive_stage #(.SLICES(SLICES)) u_drive (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .active_d_i (active_d),
      .slice_d_i  (slice_d),
      .width_d_i  (width_d),
      .drive_o    (drive_en_o)
   );

   AST_BLANK_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(slice_q) >= SLICES - BLANK_MIN) |-> !drive_en_o) else $error("tail not blanked"); // R10

   AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(drive_en_o) |-> $past(grid_start_i)) else $error("drive rose without start"); // R2

   AST_WIDTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drive_en_o |-> (active_q && WID_W'(slice_q) < width_q)) else $error("drive past width"); // R4

   AST_RESET_LOW: assert property (@(posedge clk_i)
      !rst_ni |-> !drive_en_o) else $error("drive high in reset"); // R1

endmodule

// File: tb/dim_grid_pwm_tb_top.sv
`timescale 1ns/1ps
module dim_grid_pwm_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       start = 1'b0;
   logic [2:0] level = 3'd0;
   logic       drive;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   localparam int EXP_W [8] = '{1, 2, 4, 10, 11, 12, 13, 14};

   always #2 clk = ~clk;

   dim_grid_pwm dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .slice_tick_i (tick),
      .grid_start_i (start),
      .level_i      (level),
      .drive_en_o   (drive)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: drive=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_start(input logic [2:0] lv);
      level = lv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic one_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   // Walk slices from..15, checking each, then the idle state after the end.
   task automatic walk(input int from, input int n, input string req);
      for (int k = from; k < 16; k++) begin
         check(req, drive, k < n);
         if (k >= 14) check("R10", drive, 1'b0);
         one_tick();
      end
      check("R8", drive, 1'b0);
   endtask

   task automatic t_reset();
      check("R1", drive, 1'b0);
      pulse_start(3'd7);
      one_tick();
      check("R9", drive, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", drive, 1'b0);
      one_tick();
      check("R9", drive, 1'b0);
   endtask

   task automatic t_all_levels();
      for (int c = 0; c < 8; c++) begin
         pulse_start(3'(c));
         walk(0, EXP_W[c], "R3/R4");
      end
   endtask

   task automatic t_hold();
      pulse_start(3'd0);
      check("R2", drive, 1'b1);
      repeat (12) @(negedge clk);
      check("R5", drive, 1'b1);
      one_tick();
      check("R5", drive, 1'b0);
      walk(1, 1, "R4");
   endtask

   task automatic t_level_change();
      pulse_start(3'd7);
      level = 3'd0;
      for (int k = 0; k < 16; k++) begin
         check("R6", drive, k < 14);
         if (k == 4) level = 3'd2;
         one_tick();
      end
   endtask

   task automatic t_restart();
      pulse_start(3'd1);
      for (int k = 0; k < 8; k++) one_tick();
      check("R4", drive, 1'b0);
      pulse_start(3'd4);
      walk(0, 11, "R7");
   endtask

   task automatic t_after_end();
      pulse_start(3'd5);
      walk(0, 12, "R4");
      for (int k = 0; k < 20; k++) begin
         one_tick();
         check("R8", drive, 1'b0);
      end
   endtask

   task automatic t_start_tick_same();
      level = 3'd0;
      start = 1'b1;
      tick  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      tick  = 1'b0;
      walk(0, 1, "R11");
   endtask

   task automatic t_reset_mid();
      pulse_start(3'd7);
      one_tick();
      check("R2", drive, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R1", drive, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         one_tick();
         check("R9", drive, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_all_levels();
      t_hold();
      t_level_change();
      t_restart();
      t_after_end();
      t_start_tick_same();
      t_reset_mid();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule